// File: doc/BRIEF.md
# Extended Hamming 16/11 Instruction Word Corrector

This block is a purely combinational single-error-correcting, double-error-detecting decoder for a 16-bit protected word that carries an 11-bit payload. It computes a 4-bit position syndrome and one overall parity bit from the received word. It repairs a single flipped bit wherever it lies. It then extracts the payload and reports whether a correction took place or whether the word holds an error it cannot repair.

Each data bit has a fixed home. Data bit k sits at the k-th word position that is neither 0 nor a power of two, counting upward. Positions 1, 2, 4 and 8 hold check bits. Their values make the XOR of the indices of all set bits equal to zero. Bit 0 carries even parity over the full word. The decoder sits between instruction storage and the instruction decode stage. The storage contents themselves are never rewritten.

The code size is set by a check-bit count parameter. The default of 4 gives the 16/11 format. The word and payload widths are derived from it.

Top module: `hm_decoder`

## Requirements
- R1: A codeword with no error returns its payload on `data_out`, with `err_single` and `err_double` both low. The all-zero word decodes to payload 0.
- R2: Payload bit k is taken from the k-th position that is not 0 or a power of two (3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15). The following encodings decode to their payloads: 0x401↔0x8118, 0x501↔0xA00A, 0x23C↔0x47D1, 0x14C↔0x28D7, 0x302↔0x6035, 0x000↔0x0000.
- R3: A valid codeword with exactly one bit flipped at any position from 1 to 15 returns the original payload, with `err_single` high and `err_double` low.
- R4: A valid codeword with only bit 0 flipped has a zero syndrome and odd parity. It returns the original payload, with `err_single` high and `err_double` low.
- R5: A valid codeword with exactly two bits flipped raises `err_double` and leaves `err_single` low. `data_out` then carries the payload positions of the received word unchanged.
- R6: `err_single` and `err_double` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| code_in | input | 16 | Received protected word (bit 0 overall parity, check bits at 1, 2, 4, 8) |
| data_out | output | 11 | Corrected payload, or the raw payload when a double error is flagged |
| err_single | output | 1 | A single-bit error was found and repaired |
| err_double | output | 1 | Two bit errors were found; no repair was made |

## Verification
The decoder is driven with the six fixed encodings, with an all-ones payload, and with payloads drawn at random from a fixed seed. Every payload is applied clean, with each of the 16 single-bit flips, and with each of the 120 two-bit flips. Clean words confirm the bit layout and the quiet flags. Single flips show that every position, including the parity bit at 0, is located and repaired. Double flips show detection without a wrong repair, because the output must equal the raw payload positions of the damaged word.

// File: rtl/hm_pkg.sv
package hm_pkg;

   // Position of the k-th payload bit: k-th index that is neither 0 nor 2^n.
   function automatic int data_pos(input int k);
      int cnt;
      int res;
      cnt = 0;
      res = -1;
      for (int p = 3; p < 256; p++) begin
         if (((p & (p - 1)) != 0) && (res < 0)) begin
            if (cnt == k) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

   function automatic int payload_width(input int r);
      return (1 << r) - r - 1;
   endfunction

endpackage

// File: rtl/hm_syndrome.sv
module hm_syndrome #(
   parameter int R = 4,
   localparam int N = 1 << R
) (
   input  logic [N-1:0] word,
   output logic [R-1:0] syn,
   output logic         par_odd
);

   // Mask of word positions whose index has bit b set.
   function automatic logic [N-1:0] sel_mask(input int b);
      logic [N-1:0] m;
      for (int i = 0; i < N; i++) m[i] = ((i >> b) & 1) == 1;
      return m;
   endfunction

   generate
      for (genvar b = 0; b < R; b++) begin : g_syn
         localparam logic [N-1:0] MASK = sel_mask(b);
         assign syn[b] = ^(word & MASK);
      end
   endgenerate

   assign par_odd = ^word;

endmodule

// File: rtl/hm_correct.sv
module hm_correct #(
   parameter int R = 4,
   localparam int N = 1 << R
) (
   input  logic [N-1:0] word,
   input  logic [R-1:0] syn,
   input  logic         par_odd,
   output logic [N-1:0] fixed,
   output logic         single,
   output logic         double
);

   logic [N-1:0] flip;

   generate
      for (genvar i = 0; i < N; i++) begin : g_flip
         assign flip[i] = par_odd && (syn == R'(i));
      end
   endgenerate

   assign fixed  = word ^ flip;
   assign single = par_odd;
   assign double = !par_odd && (syn != '0);

   always_comb begin
      assert_one_flip_R3: assert ($onehot0(flip))
         else $error("more than one bit inverted");
      if (single) begin
         assert_single_changes_one_R4: assert ($countones(fixed ^ word) == 1)
            else $error("single error did not change exactly one bit");
      end else begin
         assert_no_touch_R5: assert (fixed == word)
            else $error("word modified without a single error");
      end
   end

endmodule

// File: rtl/hm_extract.sv
module hm_extract #(
   parameter int R = 4,
   localparam int N = 1 << R,
   localparam int K = N - R - 1
) (
   input  logic [N-1:0] word,
   output logic [K-1:0] data
);

   generate
      for (genvar k = 0; k < K; k++) begin : g_pick
         localparam int P = hm_pkg::data_pos(k);
         if (P < 0 || P >= N) begin : g_bad
            $error("payload position out of range");
         end
         assign data[k] = word[P];
      end
   endgenerate

endmodule

// File: rtl/hm_decoder.sv
module hm_decoder #(
   parameter int CHECK_BITS = 4,
   localparam int WORD_W = 1 << CHECK_BITS,
   localparam int PAYLOAD_W = WORD_W - CHECK_BITS - 1
) (
   input  logic [WORD_W-1:0]    code_in,
   output logic [PAYLOAD_W-1:0] data_out,
   output logic                 err_single,
   output logic                 err_double
);

   generate
      if (CHECK_BITS < 2 || CHECK_BITS > 7) begin : g_range
         $error("CHECK_BITS must lie in 2..7");
      end
      if (PAYLOAD_W != hm_pkg::payload_width(CHECK_BITS)) begin : g_width
         $error("payload width mismatch");
      end
   endgenerate

   logic [CHECK_BITS-1:0] syn;
   logic                  par_odd;
   logic [WORD_W-1:0]     fixed;

   hm_syndrome #(.R(CHECK_BITS)) u_syn (
      .word    (code_in),
      .syn     (syn),
      .par_odd (par_odd)
   );

   hm_correct #(.R(CHECK_BITS)) u_fix (
      .word    (code_in),
      .syn     (syn),
      .par_odd (par_odd),
      .fixed   (fixed),
      .single  (err_single),
      .double  (err_double)
   );

   hm_extract #(.R(CHECK_BITS)) u_ext (
      .word (fixed),
      .data (data_out)
   );

   function automatic logic [CHECK_BITS-1:0] index_xor(input logic [WORD_W-1:0] w);
      logic [CHECK_BITS-1:0] s;
      s = '0;
      for (int i = 0; i < WORD_W; i++) if (w[i]) s ^= CHECK_BITS'(i);
      return s;
   endfunction

   always_comb begin
      assert_flags_exclusive_R6: assert (!(err_single && err_double))
         else $error("both error flags high");
      if (!err_double) begin
         assert_clean_after_fix_R3: assert ((index_xor(fixed) == '0) && !(^fixed))
            else $error("repaired word is not a valid codeword");
      end
   end

endmodule

// File: tb/tb_hm_decoder.sv
module tb_hm_decoder;

   logic        clk;
   logic [15:0] code_in;
   logic [10:0] data_out;
   logic        err_single;
   logic        err_double;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   hm_decoder dut (
      .code_in    (code_in),
      .data_out   (data_out),
      .err_single (err_single),
      .err_double (err_double)
   );

   initial begin
      clk = 0;
      forever #5 clk = ~clk;
   end

   function automatic logic [15:0] enc(input logic [10:0] d);
      logic [15:0] w;
      logic [3:0]  s;
      int k;
      w = '0; s = '0; k = 0;
      for (int p = 1; p < 16; p++) if ((p & (p - 1)) != 0) begin w[p] = d[k]; k++; end
      for (int p = 0; p < 16; p++) if (w[p]) s ^= 4'(p);
      for (int b = 0; b < 4; b++) w[1 << b] = s[b];
      w[0] = ^w;
      return w;
   endfunction

   function automatic logic [10:0] ext(input logic [15:0] w);
      logic [10:0] d;
      int k;
      k = 0; d = '0;
      for (int p = 1; p < 16; p++) if ((p & (p - 1)) != 0) begin d[k] = w[p]; k++; end
      return d;
   endfunction

   task automatic chk(input string req, input logic [15:0] w, input logic [10:0] ed,
                      input logic es, input logic edb);
      @(negedge clk);
      code_in = w;
      @(posedge clk);
      #1;
      total++;
      if (data_out !== ed || err_single !== es || err_double !== edb) begin
         bad++;
         $display("FAIL %s word=%h got d=%h s=%b d2=%b exp d=%h s=%b d2=%b",
                  req, w, data_out, err_single, err_double, ed, es, edb);
      end
   endtask

   task automatic sweep(input logic [10:0] d);
      logic [15:0] w;
      w = enc(d);
      chk("R1", w, d, 1'b0, 1'b0);
      for (int i = 0; i < 16; i++) begin
         if (i == 0) chk("R4", w ^ 16'h1, d, 1'b1, 1'b0);
         else        chk("R3", w ^ (16'h1 << i), d, 1'b1, 1'b0);
      end
      for (int i = 0; i < 16; i++)
         for (int j = i + 1; j < 16; j++) begin
            logic [15:0] e;
            e = w ^ (16'h1 << i) ^ (16'h1 << j);
            chk("R5_R6", e, ext(e), 1'b0, 1'b1);
         end
   endtask

   task automatic enc_chk(input logic [10:0] d, input logic [15:0] exp_w);
      total++;
      if (enc(d) !== exp_w) begin
         bad++;
         $display("FAIL R2 bench encoder %h got=%h exp=%h", d, enc(d), exp_w);
      end
      chk("R2", exp_w, d, 1'b0, 1'b0);
   endtask

   initial begin
      code_in = '0;
      repeat (2) @(posedge clk);
      #1;
      total++;
      if (data_out !== 11'h0 || err_single || err_double) begin
         bad++;
         $display("FAIL R1 zero word got d=%h s=%b d2=%b exp d=000 s=0 d2=0",
                  data_out, err_single, err_double);
      end
      enc_chk(11'h401, 16'h8118);
      enc_chk(11'h501, 16'hA00A);
      enc_chk(11'h23C, 16'h47D1);
      enc_chk(11'h14C, 16'h28D7);
      enc_chk(11'h302, 16'h6035);
      enc_chk(11'h000, 16'h0000);
      sweep(11'h401);
      sweep(11'h501);
      sweep(11'h23C);
      sweep(11'h14C);
      sweep(11'h302);
      sweep(11'h000);
      sweep(11'h7FF);
      begin
         int unsigned seed;
         seed = $urandom(32'h5EED_0017);
         for (int n = 0; n < 20; n++) sweep(11'($urandom));
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule